// File: doc/BRIEF.md
# Tagged Memory Arbiter

This block decides which of several buffer clients reaches a shared memory controller. Each cycle it looks at the clients' request lines and picks one. It then places that client's address, write data and direction on a registered request port, together with a handle equal to the client's index. Reads come back from the controller carrying the same handle. The arbiter uses that handle to steer the data to the client that asked for it. A return whose handle matches no open read is discarded and raises a sticky error flag.

After reset the arbiter belongs to a start-up loader. The loader's requests are always forwarded, and client requests are ignored. When the loader lets go, the font/color client gets first claim and the scanline clients stay blocked. That phase ends once the font/color client stops asking and has no read open. From then on a fixed order applies: host direct read, then host write buffer, then font/color, then the scanline buffers, which share one level in round-robin. While the controller holds its pause input high, no request is issued.

Clients are indexed 0 host read, 1 write buffer, 2 font/color, and 3 onward scanline buffers.

Top module: `mem_arb_top`

## Requirements
- R1: During and directly after a synchronous reset, mem_valid, cli_gnt, cli_rvalid and tag_err are all zero, and the arbiter is in its loader phase.
- R2: While ldr_active is high, no client is granted. A loader request with ldr_req high is issued one cycle later with mem_tag all ones (7 for a 3-bit handle), mem_we equal to ldr_we and mem_addr equal to ldr_addr.
- R3: The cycle after ldr_active is first seen low, issues nothing. The arbiter then enters a font phase in which client 2 wins over clients 0 and 1, and scanline clients (index 3 and up) are never granted. The phase ends after the first edge at which client 2 has its request low and no read outstanding.
- R4: After the font phase, priority is client 0, then 1, then 2, then the scanline group.
- R5: Among scanline clients, the search starts at a pointer that is 0 after reset. After scanline client j is granted, the search starts at j+1, wrapping around.
- R6: A request sampled at an edge is issued at that edge. mem_valid, mem_we, mem_addr, mem_wdata, mem_tag (the client index) and a one-hot cli_gnt are all visible after that edge, for one cycle.
- R7: When mem_pause is high at an edge, nothing is issued at that edge.
- R8: A read (cli_we low) occupies its client's handle until the data returns. A client with an open read is not granted another read. No read is issued while MAX_OUT reads are open. Writes need no handle and are granted regardless.
- R9: When rd_valid arrives with a handle that has an open read, the next cycle shows a one-hot cli_rvalid at that client's bit and cli_rdata equal to rd_data, and the handle is freed.
- R10: When rd_valid arrives with a handle that has no open read, no cli_rvalid is raised and tag_err is set. tag_err stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ldr_active | input | 1 | Start-up loader owns the memory path |
| ldr_req | input | 1 | Loader has a request |
| ldr_we | input | 1 | Loader request is a write |
| ldr_addr | input | AW | Loader address |
| ldr_wdata | input | DW | Loader write data |
| cli_req | input | NCLI | Per-client request (NCLI = 3 + NSCAN) |
| cli_we | input | NCLI | Per-client write direction |
| cli_addr | input | NCLI*AW | Client addresses, client i at bits i*AW |
| cli_wdata | input | NCLI*DW | Client write data, client i at bits i*DW |
| cli_gnt | output | NCLI | One-hot grant, registered |
| mem_pause | input | 1 | Controller holds the arbiter (refresh) |
| mem_valid | output | 1 | Request valid towards controller |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Request write data |
| mem_tag | output | TW | Return handle |
| rd_valid | input | 1 | Read data returning |
| rd_tag | input | TW | Handle of returning data |
| rd_data | input | DW | Returning data |
| cli_rvalid | output | NCLI | One-hot read-data strobe per client |
| cli_rdata | output | DW | Read data shared by all clients |
| tag_err | output | 1 | Sticky error: return with no open read |

## Verification
The bench builds the arbiter with two scanline clients, 16-bit address and data, a 3-bit handle and MAX_OUT of 4. That gives five clients against four handles, so the handle limit can be reached by four reads while a fifth client still has something to ask. With two scanline clients, the round-robin pointer wraps within a few grants. It also leaves an unused handle value (5 and 6) between the client indices and the loader's all-ones tag.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
  typedef enum logic [1:0] {PH_BOOT, PH_FONT, PH_RUN} phase_t;
  localparam int C_HOSTRD = 0;
  localparam int C_WBUF   = 1;
  localparam int C_FONT   = 2;
  localparam int C_SCAN0  = 3;
endpackage

// File: rtl/mem_arb_pick.sv
module mem_arb_pick
  import mem_arb_pkg::*;
#(
  parameter int NSCAN = 2,
  localparam int NCLI = 3 + NSCAN,
  localparam int PW = (NSCAN > 1) ? $clog2(NSCAN) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  phase_t          phase,
  input  logic [NCLI-1:0] elig,
  input  logic            take,
  output logic [NCLI-1:0] pick_oh
);
  logic [PW-1:0]    rr_q;
  logic [NSCAN-1:0] scan_el;
  logic [NSCAN-1:0] scan_oh;
  logic             scan_hit;
  int               scan_idx;

  // rotating search over the scanline group
  always_comb begin
    int j;
    scan_el  = elig[NCLI-1:C_SCAN0];
    scan_oh  = '0;
    scan_hit = 1'b0;
    scan_idx = 0;
    for (int k = 0; k < NSCAN; k++) begin
      j = (int'(rr_q) + k) % NSCAN;
      if (!scan_hit && scan_el[j]) begin
        scan_oh[j] = 1'b1;
        scan_hit   = 1'b1;
        scan_idx   = j;
      end
    end
  end

  always_comb begin
    pick_oh = '0;
    if (phase == PH_FONT) begin
      if (elig[C_FONT])        pick_oh[C_FONT]   = 1'b1;
      else if (elig[C_HOSTRD]) pick_oh[C_HOSTRD] = 1'b1;
      else if (elig[C_WBUF])   pick_oh[C_WBUF]   = 1'b1;
    end else if (phase == PH_RUN) begin
      if (elig[C_HOSTRD])      pick_oh[C_HOSTRD] = 1'b1;
      else if (elig[C_WBUF])   pick_oh[C_WBUF]   = 1'b1;
      else if (elig[C_FONT])   pick_oh[C_FONT]   = 1'b1;
      else                     pick_oh[NCLI-1:C_SCAN0] = scan_oh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (take && (|pick_oh[NCLI-1:C_SCAN0]))
      rr_q <= PW'((scan_idx + 1) % NSCAN);
  end
endmodule

// File: rtl/mem_arb_tags.sv
module mem_arb_tags #(
  parameter int NCLI    = 5,
  parameter int TW      = 3,
  parameter int DW      = 32,
  parameter int MAX_OUT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_rd,
  input  logic [TW-1:0]   issue_idx,
  input  logic            rd_valid,
  input  logic [TW-1:0]   rd_tag,
  input  logic [DW-1:0]   rd_data,
  output logic [NCLI-1:0] pend,
  output logic            room,
  output logic [NCLI-1:0] cli_rvalid,
  output logic [DW-1:0]   cli_rdata,
  output logic            tag_err
);
  logic [NCLI-1:0] hit_oh;
  logic [NCLI-1:0] pend_d;

  always_comb begin
    hit_oh = '0;
    for (int i = 0; i < NCLI; i++)
      if (rd_valid && rd_tag == TW'(i) && pend[i]) hit_oh[i] = 1'b1;
    pend_d = pend & ~hit_oh;
    for (int i = 0; i < NCLI; i++)
      if (issue_rd && issue_idx == TW'(i)) pend_d[i] = 1'b1;
  end

  assign room = $countones(pend) < MAX_OUT;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= '0;
      cli_rvalid <= '0;
      tag_err    <= 1'b0;
    end else begin
      pend       <= pend_d;
      cli_rvalid <= hit_oh;
      if (rd_valid && hit_oh == '0) tag_err <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (rd_valid) cli_rdata <= rd_data;
endmodule

// File: rtl/mem_arb_top.sv
module mem_arb_top
  import mem_arb_pkg::*;
#(
  parameter int AW      = 24,
  parameter int DW      = 32,
  parameter int NSCAN   = 2,
  parameter int TW      = 3,
  parameter int MAX_OUT = 4,
  localparam int NCLI   = 3 + NSCAN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ldr_active,
  input  logic               ldr_req,
  input  logic               ldr_we,
  input  logic [AW-1:0]      ldr_addr,
  input  logic [DW-1:0]      ldr_wdata,
  input  logic [NCLI-1:0]    cli_req,
  input  logic [NCLI-1:0]    cli_we,
  input  logic [NCLI*AW-1:0] cli_addr,
  input  logic [NCLI*DW-1:0] cli_wdata,
  output logic [NCLI-1:0]    cli_gnt,
  input  logic               mem_pause,
  output logic               mem_valid,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  output logic [TW-1:0]      mem_tag,
  input  logic               rd_valid,
  input  logic [TW-1:0]      rd_tag,
  input  logic [DW-1:0]      rd_data,
  output logic [NCLI-1:0]    cli_rvalid,
  output logic [DW-1:0]      cli_rdata,
  output logic               tag_err
);
  localparam logic [TW-1:0] LDR_TAG = '1;

  phase_t          phase;
  logic [NCLI-1:0] pend;
  logic            room;
  logic [NCLI-1:0] elig;
  logic [NCLI-1:0] pick_oh;
  logic            take;
  logic            issue_rd;
  logic [TW-1:0]   sel_idx;
  logic            sel_we;
  logic [AW-1:0]   sel_addr;
  logic [DW-1:0]   sel_wd;

  // a read needs a free handle and no read already open for the client
  always_comb
    for (int i = 0; i < NCLI; i++)
      elig[i] = cli_req[i] && (cli_we[i] || (!pend[i] && room));

  assign take = !mem_pause && (phase != PH_BOOT);

  mem_arb_pick #(.NSCAN(NSCAN)) u_pick (
    .clk(clk), .rst(rst), .phase(phase), .elig(elig),
    .take(take), .pick_oh(pick_oh)
  );

  always_comb begin
    sel_idx  = '0;
    sel_we   = 1'b0;
    sel_addr = '0;
    sel_wd   = '0;
    for (int i = 0; i < NCLI; i++)
      if (pick_oh[i]) begin
        sel_idx  = TW'(i);
        sel_we   = cli_we[i];
        sel_addr = cli_addr[i*AW +: AW];
        sel_wd   = cli_wdata[i*DW +: DW];
      end
  end

  assign issue_rd = take && (|pick_oh) && !sel_we;

  mem_arb_tags #(.NCLI(NCLI), .TW(TW), .DW(DW), .MAX_OUT(MAX_OUT)) u_tags (
    .clk(clk), .rst(rst), .issue_rd(issue_rd), .issue_idx(sel_idx),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
    .pend(pend), .room(room), .cli_rvalid(cli_rvalid),
    .cli_rdata(cli_rdata), .tag_err(tag_err)
  );

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_BOOT;
    else case (phase)
      PH_BOOT: if (!ldr_active) phase <= PH_FONT;
      PH_FONT: if (!cli_req[C_FONT] && !pend[C_FONT]) phase <= PH_RUN;
      default: phase <= PH_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      cli_gnt   <= '0;
    end else begin
      mem_valid <= 1'b0;
      cli_gnt   <= '0;
      if (!mem_pause) begin
        if (phase == PH_BOOT) begin
          if (ldr_active && ldr_req) mem_valid <= 1'b1;
        end else if (|pick_oh) begin
          mem_valid <= 1'b1;
          cli_gnt   <= pick_oh;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (phase == PH_BOOT) begin
      mem_we    <= ldr_we;
      mem_addr  <= ldr_addr;
      mem_wdata <= ldr_wdata;
      mem_tag   <= LDR_TAG;
    end else begin
      mem_we    <= sel_we;
      mem_addr  <= sel_addr;
      mem_wdata <= sel_wd;
      mem_tag   <= sel_idx;
    end
  end
endmodule

// File: rtl/mem_arb_chk.sv
module mem_arb_chk #(
  parameter int NCLI    = 5,
  parameter int TW      = 3,
  parameter int MAX_OUT = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            ldr_active,
  input logic            mem_pause,
  input logic            mem_valid,
  input logic [TW-1:0]   mem_tag,
  input logic [NCLI-1:0] cli_gnt,
  input logic [NCLI-1:0] cli_rvalid,
  input logic [NCLI-1:0] pend,
  input logic            tag_err
);
  p_gnt_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cli_gnt));

  p_gnt_tag_r6: assert property (@(posedge clk) disable iff (rst)
    (|cli_gnt) |-> (mem_valid && cli_gnt == (NCLI'(1) << mem_tag)));

  p_boot_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ldr_active |=> (cli_gnt == '0));

  p_loader_tag_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && cli_gnt == '0) |-> (mem_tag == '1));

  p_pause_r7: assert property (@(posedge clk) disable iff (rst)
    mem_pause |=> !mem_valid);

  p_out_limit_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(pend) <= MAX_OUT);

  p_rvalid_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cli_rvalid));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    tag_err |=> tag_err);
endmodule

bind mem_arb_top mem_arb_chk #(.NCLI(NCLI), .TW(TW), .MAX_OUT(MAX_OUT)) u_chk (
  .clk(clk), .rst(rst), .ldr_active(ldr_active), .mem_pause(mem_pause),
  .mem_valid(mem_valid), .mem_tag(mem_tag), .cli_gnt(cli_gnt),
  .cli_rvalid(cli_rvalid), .pend(pend), .tag_err(tag_err)
);

// File: tb/sim_mem_arb_top.sv
module sim_mem_arb_top;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NS = 2;
  localparam int TW = 3;
  localparam int NC = 3 + NS;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ldr_active = 1'b1, ldr_req = 1'b0, ldr_we = 1'b0;
  logic [AW-1:0]   ldr_addr = '0;
  logic [DW-1:0]   ldr_wdata = '0;
  logic [NC-1:0]   cli_req = '0, cli_we = '0;
  logic [NC*AW-1:0] cli_addr;
  logic [NC*DW-1:0] cli_wdata;
  logic [NC-1:0]   cli_gnt;
  logic            mem_pause = 1'b0;
  logic            mem_valid, mem_we;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata;
  logic [TW-1:0]   mem_tag;
  logic            rd_valid = 1'b0;
  logic [TW-1:0]   rd_tag = '0;
  logic [DW-1:0]   rd_data = '0;
  logic [NC-1:0]   cli_rvalid;
  logic [DW-1:0]   cli_rdata;
  logic            tag_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mem_arb_top #(.AW(AW), .DW(DW), .NSCAN(NS), .TW(TW), .MAX_OUT(4)) u0 (
    .clk(clk), .rst(rst), .ldr_active(ldr_active), .ldr_req(ldr_req),
    .ldr_we(ldr_we), .ldr_addr(ldr_addr), .ldr_wdata(ldr_wdata),
    .cli_req(cli_req), .cli_we(cli_we), .cli_addr(cli_addr),
    .cli_wdata(cli_wdata), .cli_gnt(cli_gnt), .mem_pause(mem_pause),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_tag(mem_tag), .rd_valid(rd_valid),
    .rd_tag(rd_tag), .rd_data(rd_data), .cli_rvalid(cli_rvalid),
    .cli_rdata(cli_rdata), .tag_err(tag_err)
  );

  // {req[4:0], pause, expect_valid, expect_gnt[4:0]}, all requests are writes
  localparam logic [11:0] TBL [0:10] = '{
    12'b11111_0_1_00001,  // R4 host read first
    12'b11110_0_1_00010,  // R4 write buffer next
    12'b11100_0_1_00100,  // R4 font over scanline
    12'b11000_0_1_01000,  // R5 pointer starts at scan 0
    12'b11000_0_1_10000,  // R5 moves to scan 1
    12'b11000_0_1_01000,  // R5 wraps
    12'b10000_0_1_10000,  // R5 lone scan 1
    12'b11000_1_0_00000,  // R7 pause
    12'b11000_0_1_01000,  // R5 pointer held over pause
    12'b00000_0_0_00000,  // R6 idle
    12'b00110_0_1_00010   // R4 write buffer over font
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic drive(input logic [NC-1:0] rq, input logic [NC-1:0] w, input logic p);
    cli_req   = rq;
    cli_we    = w;
    mem_pause = p;
    @(negedge clk);
  endtask

  function automatic int oh_idx(input logic [NC-1:0] v);
    int r = 0;
    for (int i = 0; i < NC; i++) if (v[i]) r = i;
    return r;
  endfunction

  initial begin
    for (int i = 0; i < NC; i++) begin
      cli_addr[i*AW +: AW]  = AW'(16'h0100 + i);
      cli_wdata[i*DW +: DW] = DW'(16'hA000 + i);
    end
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(mem_valid), 0);
    chk("R1 gnt in reset", 32'(cli_gnt), 0);
    chk("R1 rvalid in reset", 32'(cli_rvalid), 0);
    chk("R1 err in reset", 32'(tag_err), 0);
    rst = 1'b0;

    // loader phase
    ldr_req = 1'b1; ldr_we = 1'b1; ldr_addr = 16'h0BEE; ldr_wdata = 16'h7777;
    drive(5'b00101, 5'b11111, 1'b0);
    chk("R2 loader valid", 32'(mem_valid), 1);
    chk("R2 loader tag", 32'(mem_tag), 7);
    chk("R2 loader addr", 32'(mem_addr), 32'h0BEE);
    chk("R2 loader we", 32'(mem_we), 1);
    chk("R2 clients held", 32'(cli_gnt), 0);
    ldr_req = 1'b0;
    drive(5'b00101, 5'b11111, 1'b0);
    chk("R2 no loader req", 32'(mem_valid), 0);

    // font phase
    ldr_active = 1'b0;
    drive(5'b00100, 5'b11111, 1'b0);
    chk("R3 handover cycle idle", 32'(mem_valid), 0);
    drive(5'b10101, 5'b11111, 1'b0);
    chk("R3 font first", 32'(cli_gnt), 32'b00100);
    drive(5'b11000, 5'b11111, 1'b0);
    chk("R3 scanline masked", 32'(mem_valid), 0);

    // run phase table
    for (int v = 0; v < 11; v++) begin
      drive(TBL[v][11:7], 5'b11111, TBL[v][6]);
      chk($sformatf("R4/R5/R7 vector %0d valid", v), 32'(mem_valid), 32'(TBL[v][5]));
      chk($sformatf("R4/R5/R7 vector %0d gnt", v), 32'(cli_gnt), 32'(TBL[v][4:0]));
      if (TBL[v][5]) begin
        chk($sformatf("R6 vector %0d tag", v), 32'(mem_tag), 32'(oh_idx(TBL[v][4:0])));
        chk($sformatf("R6 vector %0d addr", v), 32'(mem_addr), 32'h0100 + 32'(oh_idx(TBL[v][4:0])));
        chk($sformatf("R6 vector %0d wdata", v), 32'(mem_wdata), 32'hA000 + 32'(oh_idx(TBL[v][4:0])));
      end
    end

    // handles
    drive(5'b00100, 5'b00000, 1'b0);
    chk("R8 read issued we", 32'(mem_we), 0);
    chk("R8 read tag", 32'(mem_tag), 2);
    rd_valid = 1'b1; rd_tag = 3'd2; rd_data = 16'h5A5A;
    drive(5'b00000, 5'b00000, 1'b0);
    chk("R9 routed to client 2", 32'(cli_rvalid), 32'b00100);
    chk("R9 data", 32'(cli_rdata), 32'h5A5A);
    chk("R10 no error on good tag", 32'(tag_err), 0);
    drive(5'b00000, 5'b00000, 1'b0);
    chk("R10 stray return dropped", 32'(cli_rvalid), 0);
    chk("R10 error raised", 32'(tag_err), 1);
    rd_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      drive(NC'(1) << i, 5'b00000, 1'b0);
      chk($sformatf("R8 read %0d granted", i), 32'(cli_gnt), 32'(1) << i);
    end
    drive(5'b00001, 5'b00000, 1'b0);
    chk("R8 open read blocks client", 32'(mem_valid), 0);
    drive(5'b10000, 5'b00000, 1'b0);
    chk("R8 handle limit blocks read", 32'(mem_valid), 0);
    drive(5'b00010, 5'b00010, 1'b0);
    chk("R8 write needs no handle", 32'(cli_gnt), 32'b00010);
    rd_valid = 1'b1; rd_tag = 3'd1; rd_data = 16'h1234;
    drive(5'b00000, 5'b00000, 1'b0);
    rd_valid = 1'b0;
    chk("R9 routed to client 1", 32'(cli_rvalid), 32'b00010);
    chk("R9 data 1", 32'(cli_rdata), 32'h1234);
    chk("R10 error sticky", 32'(tag_err), 1);
    drive(5'b10000, 5'b00000, 1'b0);
    chk("R8 freed handle reused", 32'(cli_gnt), 32'b10000);
    chk("R8 reused tag", 32'(mem_tag), 4);
    cli_req = '0;
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears error", 32'(tag_err), 0);
    rst = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule